// File: doc/BRIEF.md
# Third-Order Cascaded Divider-Control Modulator with Residue Export

This block produces the modulus sequence for a fractional-N feedback divider. It is driven by one step strobe per reference cycle. At each strobe it takes a 21-bit fractional word, a signed half-scale offset selection and the integer divide value. It advances three cascaded first-order accumulators. The overflow bits of the three accumulators are combined through a noise-shaping network into a signed modulus increment. That increment, added to the integer value, is the registered divide word.

The third accumulator holds the residue that the cascade never passes on. The block exports the top 6 bits of that residue on every strobe. A downstream cancellation converter uses it. The lower bits are simply dropped, and the cancellation path shapes that truncation error.

The half-scale offset moves the synthesised fraction by plus or minus one half. Fractional spurs are then pushed away from the loop bandwidth, and a later re-timing stage removes the shift. When the offset pushes the fraction outside [0, 1), the whole unit is carried into the integer increment. In that way +0.5 and -0.5 give different divide sequences.

Top module: `mash111_mod`

## Requirements
- R1: A synchronous active-high reset clears all three accumulators, the carry delay registers and every output. After reset, mod_valid, mod_inc, mod_word and err_word all read 0.
- R2: mod_valid is high for exactly the one cycle that follows a cycle with step high, and is low at all other times. While step is low, no accumulator or delay register advances, and mod_word, mod_inc and err_word hold their values.
- R3: offset_sel encodes the offset added to frac_word ahead of the first accumulator. 2'b01 adds 2^20, 2'b10 subtracts 2^20, and 2'b00 and 2'b11 add nothing. If the sum reaches 2^21, the fraction wraps and +1 joins the increment. If the sum is negative, the fraction wraps and -1 joins the increment.
- R4: Each of the three accumulators adds, modulo 2^21, its input: the offset fraction for the first stage, and the updated residue of the stage before it for the others. Each accumulator flags a carry when the sum wraps.
- R5: The increment is c1 + c2[n] - c2[n-1] + c3[n] - 2*c3[n-1] + c3[n-2] plus the R3 adjustment. It is output as the 5-bit two's-complement mod_inc on the cycle after the step.
- R6: mod_word equals int_n (as sampled with the step) plus the sign-extended mod_inc, modulo 2^8, and is valid together with mod_valid.
- R7: err_word carries bits [20:15] of the third accumulator's value after the update of that step.
- R8: With frac_word = 0 and no offset from reset onward, every mod_inc and err_word is 0 and mod_word equals int_n.
- R9: mod_inc always lies in the range -4 to +5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the step strobe marks reference cycles |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the modulator once on this cycle |
| frac_word | input | 21 | Unsigned fractional control word |
| offset_sel | input | 2 | Half-scale offset code: 00 none, 01 +half, 10 -half, 11 none |
| int_n | input | 8 | Integer divide value |
| mod_valid | output | 1 | New modulus and residue words present |
| mod_inc | output | 5 | Signed modulus increment |
| mod_word | output | 8 | Divide value for this reference cycle |
| err_word | output | 6 | Top bits of the third-stage residue |

## Verification
A corrupted first accumulator changes c1 and every residue below it. The mod_inc and err_word sequence then departs from the bench model on the very next valid word. Damage to the second or third stage, or to a carry delay register, shows in mod_inc within one to two strobes, as the differenced carry terms reach the sum. A fault in the third stage also shows at once in err_word. An offset or borrow error appears as a constant ±1 bias in mod_inc on each affected strobe. The bench therefore compares every valid word in order against a step-by-step model, so a divergence is caught at the first word it touches.

// File: rtl/mash_pkg.sv
package mash_pkg;
  // Width of the signed modulus increment (range -4..+5)
  localparam int INC_W = 5;

  // Half-scale offset selection
  typedef enum logic [1:0] {
    OFS_NONE = 2'b00,
    OFS_UP   = 2'b01,
    OFS_DN   = 2'b10,
    OFS_RSV  = 2'b11
  } ofs_e;
endpackage

// File: rtl/mash_ofs_add.sv
module mash_ofs_add
  import mash_pkg::*;
#(
  parameter int FRAC_W = 21
) (
  input  logic [FRAC_W-1:0] frac_in,
  input  ofs_e              sel,
  output logic [FRAC_W-1:0] frac_out,
  output logic signed [1:0] int_adj
);
  localparam int SUM_W = FRAC_W + 2;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC_W - 1);

  logic signed [SUM_W-1:0] half_term;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    case (sel)
      OFS_UP:  half_term = HALF;
      OFS_DN:  half_term = -HALF;
      default: half_term = '0;
    endcase
    sum = $signed({2'b00, frac_in}) + half_term;
    // wrap back into [0, 2^FRAC_W) and report the whole unit moved out
    frac_out = sum[FRAC_W-1:0];
    if (sum < 0)
      int_adj = -2'sd1;
    else if (sum[FRAC_W])
      int_adj = 2'sd1;
    else
      int_adj = 2'sd0;
  end
endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         carry,
  output logic [W-1:0] res_next,
  output logic [W-1:0] acc_q
);
  logic [W:0] sum;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, din};
    carry    = sum[W];
    res_next = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (en)
      acc_q <= res_next;
  end

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));

  // R4
  acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    carry |-> (res_next < din));
endmodule

// File: rtl/mash_recomb.sv
module mash_recomb #(
  parameter int OUT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    c1,
  input  logic                    c2,
  input  logic                    c3,
  input  logic signed [1:0]       adj,
  output logic signed [OUT_W-1:0] inc_next
);
  logic c2_d1;
  logic c3_d1;
  logic c3_d2;

  function automatic logic signed [OUT_W-1:0] bit_ext(input logic b);
    return signed'({{(OUT_W-1){1'b0}}, b});
  endfunction

  logic signed [OUT_W-1:0] adj_ext;
  logic signed [OUT_W-1:0] first_term;
  logic signed [OUT_W-1:0] second_term;
  logic signed [OUT_W-1:0] third_term;

  always_comb begin
    adj_ext     = signed'({{(OUT_W-2){adj[1]}}, adj});
    first_term  = bit_ext(c1);
    second_term = bit_ext(c2) - bit_ext(c2_d1);
    third_term  = bit_ext(c3) - (bit_ext(c3_d1) <<< 1) + bit_ext(c3_d2);
    inc_next    = first_term + second_term + third_term + adj_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (en) begin
      c2_d1 <= c2;
      c3_d1 <= c3;
      c3_d2 <= c3_d1;
    end
  end

  // R2
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({c2_d1, c3_d1, c3_d2}));

  // R5
  delay_shift_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (c3_d2 == $past(c3_d1)));
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
  import mash_pkg::*;
#(
  parameter int FRAC_W = 21,
  parameter int ERR_W  = 6,
  parameter int INT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [1:0]        offset_sel,
  input  logic [INT_W-1:0]  int_n,
  output logic              mod_valid,
  output logic [INC_W-1:0]  mod_inc,
  output logic [INT_W-1:0]  mod_word,
  output logic [ERR_W-1:0]  err_word
);
  localparam int NSTAGE = 3;
  localparam int EXT_W  = INT_W - INC_W;

  logic [FRAC_W-1:0]       stage_in  [NSTAGE];
  logic [FRAC_W-1:0]       stage_res [NSTAGE];
  logic [FRAC_W-1:0]       stage_acc [NSTAGE];
  logic [NSTAGE-1:0]       stage_cy;
  logic signed [1:0]       int_adj;
  logic signed [INC_W-1:0] inc_next;
  logic [INT_W-1:0]        word_next;

  mash_ofs_add #(.FRAC_W(FRAC_W)) u_ofs (
    .frac_in  (frac_word),
    .sel      (ofs_e'(offset_sel)),
    .frac_out (stage_in[0]),
    .int_adj  (int_adj)
  );

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign stage_in[i] = stage_res[i-1];
    end
    mash_acc_stage #(.W(FRAC_W)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .en       (step),
      .din      (stage_in[i]),
      .carry    (stage_cy[i]),
      .res_next (stage_res[i]),
      .acc_q    (stage_acc[i])
    );
  end

  mash_recomb #(.OUT_W(INC_W)) u_rec (
    .clk      (clk),
    .rst      (rst),
    .en       (step),
    .c1       (stage_cy[0]),
    .c2       (stage_cy[1]),
    .c3       (stage_cy[2]),
    .adj      (int_adj),
    .inc_next (inc_next)
  );

  assign word_next = int_n + {{EXT_W{inc_next[INC_W-1]}}, inc_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_valid <= 1'b0;
      mod_inc   <= '0;
      mod_word  <= '0;
      err_word  <= '0;
    end else begin
      mod_valid <= step;
      if (step) begin
        mod_inc  <= inc_next;
        mod_word <= word_next;
        err_word <= stage_res[NSTAGE-1][FRAC_W-1 -: ERR_W];
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mod_valid && mod_inc == '0 && mod_word == '0 && err_word == '0));

  // R2
  valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    mod_valid |-> $past(step));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(mod_word) && $stable(mod_inc) && $stable(err_word) && !mod_valid));

  // R6
  word_sum_chk: assert property (@(posedge clk) disable iff (rst)
    mod_valid |-> (mod_word == $past(int_n) + {{EXT_W{mod_inc[INC_W-1]}}, mod_inc}));

  // R7
  err_tap_chk: assert property (@(posedge clk) disable iff (rst)
    mod_valid |-> (err_word == stage_acc[NSTAGE-1][FRAC_W-1 -: ERR_W]));

  // R9
  inc_range_chk: assert property (@(posedge clk) disable iff (rst)
    mod_valid |-> ($signed(mod_inc) >= -4 && $signed(mod_inc) <= 5));
endmodule

// File: tb/mash111_mod_test.sv
module mash111_mod_test;
  localparam int  FW = 21;
  localparam longint M = 64'd1 << FW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [20:0] frac_word = '0;
  logic [1:0]  offset_sel = 2'b00;
  logic [7:0]  int_n = '0;
  logic        mod_valid;
  logic [4:0]  mod_inc;
  logic [7:0]  mod_word;
  logic [5:0]  err_word;

  mash111_mod uut (
    .clk(clk), .rst(rst), .step(step), .frac_word(frac_word),
    .offset_sel(offset_sel), .int_n(int_n), .mod_valid(mod_valid),
    .mod_inc(mod_inc), .mod_word(mod_word), .err_word(err_word)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    inc;
    int    word;
    int    err;
    string req;
  } exp_t;

  exp_t   sb[$];
  int     n_checks = 0;
  int     n_fail = 0;
  int     last_word = 0;
  bit     finished = 0;
  longint a1, a2, a3;
  int     c2d, c3d, c3dd;

  task automatic model_reset();
    a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: apply one step and push the expected result
  task automatic drive(input int k, input int sel, input int n, input string req);
    longint off, sum, x, s;
    int adj, c1, c2, c3, y;
    exp_t e;
    @(negedge clk);
    frac_word = 21'(k); offset_sel = 2'(sel); int_n = 8'(n); step = 1'b1;
    off = (sel == 1) ? M / 2 : (sel == 2) ? -(M / 2) : 0;
    sum = longint'(k) + off;
    adj = (sum < 0) ? -1 : (sum >= M) ? 1 : 0;
    x = sum - adj * M;
    s = a1 + x;  c1 = (s >= M); a1 = s % M;
    s = a2 + a1; c2 = (s >= M); a2 = s % M;
    s = a3 + a2; c3 = (s >= M); a3 = s % M;
    y = c1 + c2 - c2d + c3 - 2 * c3d + c3dd + adj;
    c3dd = c3d; c3d = c3; c2d = c2;
    e.inc = y; e.word = (n + y) & 255; e.err = int'(a3 >> (FW - 6)); e.req = req;
    last_word = e.word;
    sb.push_back(e);
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    step = 1'b0;
    for (int i = 1; i < cycles; i++) @(negedge clk);
  endtask

  // R2: after a gap, no valid and held word
  task automatic hold_check();
    check(mod_valid == 1'b0, "R2", "valid during gap", int'(mod_valid), 0);
    check(int'(mod_word) == last_word, "R2", "word held during gap", int'(mod_word), last_word);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && mod_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check($signed(mod_inc) == e.inc, e.req, "mod_inc", int'($signed(mod_inc)), e.inc);
        check(int'(mod_word) == e.word, e.req, "mod_word", int'(mod_word), e.word);
        check(int'(err_word) == e.err, e.req, "err_word", int'(err_word), e.err);
      end
    end
  end

  task automatic reset_check();
    check(mod_valid == 1'b0, "R1", "valid after reset", int'(mod_valid), 0);
    check(mod_inc == '0, "R1", "mod_inc after reset", int'(mod_inc), 0);
    check(mod_word == '0, "R1", "mod_word after reset", int'(mod_word), 0);
    check(err_word == '0, "R1", "err_word after reset", int'(err_word), 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_check();

    // R8: zero input gives zero increment and residue
    for (int i = 0; i < 24; i++) drive(0, 0, 40, "R8");
    idle(3);

    // R4/R5: quarter-scale fraction
    for (int i = 0; i < 40; i++) drive(1 << 19, 0, 40, "R5");
    // R4: odd fraction with gaps between steps
    for (int i = 0; i < 30; i++) begin
      drive(12345, 0, 60, "R4");
      idle(2);
      hold_check();
    end

    // R3: +half with overflow into the integer part
    for (int i = 0; i < 20; i++) drive(int'(M) - 100, 1, 100, "R3");
    // R3: -half with borrow from the integer part
    for (int i = 0; i < 20; i++) drive(100, 2, 100, "R3");
    // R3: reserved code adds nothing
    for (int i = 0; i < 12; i++) drive(777777, 3, 100, "R3");
    // R3: +half without overflow
    for (int i = 0; i < 12; i++) drive(300000, 1, 100, "R3");

    // R6: integer value changing every step, wrap near 255
    for (int i = 0; i < 24; i++) drive(999999, 0, 250 + i, "R6");

    // R7: near full-scale fraction exercises the residue top bits
    for (int i = 0; i < 30; i++) drive(int'(M) - 1, 0, 80, "R7");
    idle(3);
    hold_check();

    // R1: reset in mid-run
    drive(555555, 1, 90, "R5");
    idle(2);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    sb.delete();
    last_word = 0;
    @(negedge clk);
    reset_check();
    for (int i = 0; i < 16; i++) drive(1048577, 2, 30, "R9");
    idle(3);

    check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule